// File: doc/BRIEF.md
# Zero-Suppressed Sparse Readout Scanner

This block drains one event from a parallel channel buffer onto a narrow output bus and sends only the channels that carry a hit. A start pulse loads a snapshot of every channel's hit flag and stored 8-bit conversion value. The scanner then walks the channels in ascending order. For each hit channel it puts two words on the bus: first the channel number, then that channel's value. When no hit remains, it raises a one-cycle end-of-readout flag.

Empty channels are dropped while the readout runs, with no compaction pass before the first word. A priority encoder looks at a window of channels just past the last one sent. When the next hit falls inside that window, its address word follows the previous value word with no gap. When the window is empty, the scanner moves the window forward, spends one idle bus cycle, and tries again. Only sparse events pay that cost. Everything runs on the readout clock.

Top module: `zs_readout_scanner`

## Requirements
- R1: A start pulse seen while idle loads the hit flags and values. The cycle after that edge shows valid, end-of-readout and the bus all low, and the first output word can appear one edge later.
- R2: Each hit channel gives two consecutive bus words with valid high. The first is the channel number zero-extended to 8 bits. The second is the channel's value, taken from bits [8*ch+7:8*ch] of the values input.
- R3: Channels are sent in strictly ascending order. A channel whose hit flag is clear never appears on the bus.
- R4: If the next hit lies within the 16 channels that follow the previous hit, its address word comes in the cycle right after the previous value word.
- R5: For each block of 16 channels, starting at the search position, that holds no hit while a later hit still exists, the scanner spends exactly one cycle with valid low and the bus at zero.
- R6: End-of-readout is high for exactly one cycle, in the cycle right after the last value word. Valid is low in that cycle and the block is idle afterwards.
- R7: An event with no hits raises end-of-readout in the second cycle after the start edge and sends no data words.
- R8: A start pulse that arrives during readout has no effect: the word stream of the running event and its end are unchanged.
- R9: Synchronous active-high reset forces valid, end-of-readout and the bus to zero and returns the block to idle, including in the middle of a readout.
- R10: Valid and end-of-readout are never high together, and the bus reads zero whenever valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Readout clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse: load the event and begin readout |
| hits_i | input | 128 | Hit flag per channel, bit n for channel n |
| values_i | input | 1024 | Stored value per channel, 8 bits each, channel n at [8n+7:8n] |
| data_o | output | 8 | Output bus: address word or value word |
| valid_o | output | 1 | High when data_o carries a word |
| eor_o | output | 1 | One-cycle end-of-readout flag |

## Verification
A bad search position or stale window shows at the ports as a skipped hit, a repeated or out-of-order address, or an extra idle cycle. The per-cycle scoreboard flags any of these in the first cycle they occur. A broken state machine shows up the same way: it can drop a value word after an address, miss or repeat end-of-readout, or reload on a mid-readout start. Each of these changes the next one or two bus cycles, so a mismatch is reported in the cycle it happens, not at the end of the event. Sparse patterns place hits at gaps of exactly 16 and 17 channels so that the window edge is tested on both sides.

// File: rtl/zs_pkg.sv
package zs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEEK = 2'd1,
    ST_VAL  = 2'd2
  } scan_state_e;

  // Position of the first channel after a hit that has just been sent.
  function automatic int unsigned resume_after(input int unsigned ch);
    return ch + 1;
  endfunction

  // Position after skipping one empty lookahead window.
  function automatic int unsigned skip_window(input int unsigned pos, input int unsigned win);
    return pos + win;
  endfunction
endpackage

// File: rtl/zs_event_store.sv
module zs_event_store #(
  parameter int N_CH   = 128,
  parameter int DATA_W = 8,
  parameter int ADDR_W = $clog2(N_CH)
) (
  input  logic                     clk_i,
  input  logic                     rst_i,
  input  logic                     load_i,
  input  logic [N_CH-1:0]          hits_i,
  input  logic [N_CH*DATA_W-1:0]   values_i,
  input  logic [ADDR_W-1:0]        sel_i,
  output logic [N_CH-1:0]          hits_q_o,
  output logic [DATA_W-1:0]        sel_val_o
);
  logic [N_CH*DATA_W-1:0] vals_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hits_q_o <= '0;
    end else if (load_i) begin
      hits_q_o <= hits_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (load_i) vals_q <= values_i;
  end

  assign sel_val_o = vals_q[sel_i*DATA_W +: DATA_W];
endmodule

// File: rtl/zs_window_finder.sv
module zs_window_finder #(
  parameter int N_CH   = 128,
  parameter int WIN    = 16,
  parameter int ADDR_W = $clog2(N_CH),
  parameter int POS_W  = ADDR_W + 1
) (
  input  logic [N_CH-1:0]   hits_i,
  input  logic [POS_W-1:0]  pos_i,
  output logic              hit_in_win_o,
  output logic [ADDR_W-1:0] hit_ch_o,
  output logic              any_left_o
);
  localparam int IDX_W = POS_W + 1;
  localparam int OFF_W = (WIN > 1) ? $clog2(WIN) : 1;

  logic [WIN-1:0]  cand;
  logic [N_CH-1:0] ahead;
  logic [OFF_W-1:0] off;
  logic [IDX_W-1:0] sum;

  for (genvar k = 0; k < WIN; k++) begin : g_win
    logic [IDX_W-1:0] idx;
    assign idx     = IDX_W'(pos_i) + IDX_W'(k);
    assign cand[k] = (idx < IDX_W'(N_CH)) && hits_i[idx[ADDR_W-1:0]];
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_ahead
    assign ahead[i] = hits_i[i] && (IDX_W'(i) >= IDX_W'(pos_i));
  end

  always_comb begin
    off = '0;
    for (int k = WIN - 1; k >= 0; k--) begin
      if (cand[k]) off = OFF_W'(k);
    end
  end

  assign sum          = IDX_W'(pos_i) + IDX_W'(off);
  assign hit_ch_o     = sum[ADDR_W-1:0];
  assign hit_in_win_o = |cand;
  assign any_left_o   = |ahead;
endmodule

// File: rtl/zs_scan_ctrl.sv
module zs_scan_ctrl
  import zs_pkg::*;
#(
  parameter int N_CH   = 128,
  parameter int WIN    = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = $clog2(N_CH),
  parameter int POS_W  = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              start_i,
  input  logic              hit_in_win_i,
  input  logic [ADDR_W-1:0] hit_ch_i,
  input  logic              any_left_i,
  input  logic [DATA_W-1:0] sel_val_i,
  output logic              capture_o,
  output logic              busy_o,
  output logic [POS_W-1:0]  pos_o,
  output logic [ADDR_W-1:0] cur_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              eor_o,
  output logic              val_word_o
);
  scan_state_e state_q;

  assign capture_o = start_i && (state_q == ST_IDLE);
  assign busy_o    = (state_q != ST_IDLE);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q    <= ST_IDLE;
      pos_o      <= '0;
      cur_o      <= '0;
      data_o     <= '0;
      valid_o    <= 1'b0;
      eor_o      <= 1'b0;
      val_word_o <= 1'b0;
    end else begin
      data_o     <= '0;
      valid_o    <= 1'b0;
      eor_o      <= 1'b0;
      val_word_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (capture_o) begin
            pos_o   <= '0;
            state_q <= ST_SEEK;
          end
        end
        ST_SEEK: begin
          if (!any_left_i) begin
            eor_o   <= 1'b1;
            state_q <= ST_IDLE;
          end else if (hit_in_win_i) begin
            data_o  <= DATA_W'(hit_ch_i);
            valid_o <= 1'b1;
            cur_o   <= hit_ch_i;
            state_q <= ST_VAL;
          end else begin
            pos_o <= POS_W'(skip_window(int'(pos_o), WIN));
          end
        end
        ST_VAL: begin
          data_o     <= sel_val_i;
          valid_o    <= 1'b1;
          val_word_o <= 1'b1;
          pos_o      <= POS_W'(resume_after(int'(cur_o)));
          state_q    <= ST_SEEK;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/zs_readout_scanner.sv
module zs_readout_scanner #(
  parameter int N_CH   = 128,
  parameter int WIN    = 16,
  parameter int DATA_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_i,
  input  logic                   start_i,
  input  logic [N_CH-1:0]        hits_i,
  input  logic [N_CH*DATA_W-1:0] values_i,
  output logic [DATA_W-1:0]      data_o,
  output logic                   valid_o,
  output logic                   eor_o
);
  localparam int ADDR_W = $clog2(N_CH);
  localparam int POS_W  = ADDR_W + 1;

  // Named internal events, visible to the bound checker.
  logic              capture;
  logic              busy;
  logic              val_word;
  logic [N_CH-1:0]   hit_q;
  logic [POS_W-1:0]  pos;
  logic [ADDR_W-1:0] cur;
  logic              hit_in_win;
  logic [ADDR_W-1:0] hit_ch;
  logic              any_left;
  logic [DATA_W-1:0] sel_val;

  zs_event_store #(.N_CH(N_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .load_i    (capture),
    .hits_i    (hits_i),
    .values_i  (values_i),
    .sel_i     (cur),
    .hits_q_o  (hit_q),
    .sel_val_o (sel_val)
  );

  zs_window_finder #(.N_CH(N_CH), .WIN(WIN), .ADDR_W(ADDR_W), .POS_W(POS_W)) u_find (
    .hits_i       (hit_q),
    .pos_i        (pos),
    .hit_in_win_o (hit_in_win),
    .hit_ch_o     (hit_ch),
    .any_left_o   (any_left)
  );

  zs_scan_ctrl #(.N_CH(N_CH), .WIN(WIN), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .POS_W(POS_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .start_i      (start_i),
    .hit_in_win_i (hit_in_win),
    .hit_ch_i     (hit_ch),
    .any_left_i   (any_left),
    .sel_val_i    (sel_val),
    .capture_o    (capture),
    .busy_o       (busy),
    .pos_o        (pos),
    .cur_o        (cur),
    .data_o       (data_o),
    .valid_o      (valid_o),
    .eor_o        (eor_o),
    .val_word_o   (val_word)
  );
endmodule

// File: rtl/zs_scanner_checker.sv
module zs_scanner_checker #(
  parameter int N_CH   = 128,
  parameter int DATA_W = 8,
  parameter int ADDR_W = $clog2(N_CH)
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              start_i,
  input logic              capture,
  input logic              busy,
  input logic              val_word,
  input logic [N_CH-1:0]   hit_q,
  input logic [DATA_W-1:0] data_o,
  input logic              valid_o,
  input logic              eor_o
);
  logic              seen_q;
  logic [ADDR_W-1:0] last_q;
  logic              addr_word;

  assign addr_word = valid_o && !val_word;

  always_ff @(posedge clk_i) begin
    if (rst_i || capture) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (addr_word) begin
      seen_q <= 1'b1;
      last_q <= data_o[ADDR_W-1:0];
    end
  end

  assert_excl_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    !(valid_o && eor_o));

  assert_bus_quiet_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    !valid_o |-> (data_o == '0));

  assert_eor_pulse_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    eor_o |=> !eor_o);

  assert_value_follows_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    addr_word |=> (valid_o && val_word));

  assert_hit_only_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    addr_word |-> hit_q[data_o[ADDR_W-1:0]]);

  assert_ascending_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (addr_word && seen_q) |-> (data_o[ADDR_W-1:0] > last_q));

  assert_start_ignored_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (start_i && busy) |=> $stable(hit_q));

  assert_reset_quiet_R9: assert property (@(posedge clk_i)
    rst_i |=> (!valid_o && !eor_o && !busy));
endmodule

bind zs_readout_scanner zs_scanner_checker #(.N_CH(N_CH), .DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .start_i  (start_i),
  .capture  (capture),
  .busy     (busy),
  .val_word (val_word),
  .hit_q    (hit_q),
  .data_o   (data_o),
  .valid_o  (valid_o),
  .eor_o    (eor_o)
);

// File: tb/zs_readout_scanner_bench.sv
module zs_readout_scanner_bench;
  localparam int N  = 128;
  localparam int W  = 8;
  localparam int WN = 16;

  typedef struct {
    bit       v;
    bit [7:0] d;
    bit       e;
    string    tag;
  } exp_t;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [N-1:0]   hits = '0;
  logic [N*W-1:0] vals = '0;
  logic [W-1:0]   data;
  logic           valid;
  logic           eor;

  int   total = 0;
  int   bad   = 0;
  bit   armed = 1'b0;
  exp_t exp_q[$];
  int   cyc = 0;

  zs_readout_scanner u_zs_readout_scanner (
    .clk_i    (clk),
    .rst_i    (rst),
    .start_i  (start),
    .hits_i   (hits),
    .values_i (vals),
    .data_o   (data),
    .valid_o  (valid),
    .eor_o    (eor)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h (t=%0t)", tag, what, act, expv, $time);
    end
  endtask

  // Monitor: compares one expected bus cycle per falling edge.
  always @(negedge clk) begin
    if (armed && exp_q.size() > 0) begin
      exp_t x;
      x = exp_q.pop_front();
      check(valid == x.v, x.tag, "valid", int'(valid), int'(x.v));
      check(eor == x.e, x.tag, "eor", int'(eor), int'(x.e));
      check(data == x.d, x.tag, "bus", int'(data), int'(x.d));
    end
  end

  // Watchdog.
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic bit [7:0] val_for(input int ch, input int seed);
    return 8'((ch * 37 + seed * 11 + 5) & 8'hFF);
  endfunction

  // Expected stream built from the requirements, one entry per bus cycle.
  task automatic push_expected(input logic [N-1:0] h, input int seed, input string tail_tag);
    int  p;
    bit  after_val;
    exp_t x;
    p = 0;
    after_val = 1'b0;
    x = '{v:0, d:0, e:0, tag:"R1"};
    exp_q.push_back(x);
    forever begin
      int nxt;
      nxt = -1;
      for (int c = p; c < N; c++) if (h[c] && nxt < 0) nxt = c;
      if (nxt < 0) begin
        x = '{v:0, d:0, e:1, tag:(h == '0) ? "R7" : "R6"};
        exp_q.push_back(x);
        break;
      end
      if (nxt < p + WN) begin
        x = '{v:1, d:8'(nxt), e:0, tag:after_val ? "R4" : "R3"};
        exp_q.push_back(x);
        x = '{v:1, d:val_for(nxt, seed), e:0, tag:"R2"};
        exp_q.push_back(x);
        after_val = 1'b1;
        p = nxt + 1;
      end else begin
        x = '{v:0, d:0, e:0, tag:"R5"};
        exp_q.push_back(x);
        after_val = 1'b0;
        p = p + WN;
      end
    end
    for (int k = 0; k < 2; k++) begin
      x = '{v:0, d:0, e:0, tag:tail_tag};
      exp_q.push_back(x);
    end
  endtask

  task automatic run_event(input logic [N-1:0] h, input int seed, input bit poke);
    @(negedge clk);
    hits = h;
    for (int c = 0; c < N; c++) vals[c*W +: W] = val_for(c, seed);
    start = 1'b1;
    @(posedge clk);
    #1;
    start = 1'b0;
    push_expected(h, seed, poke ? "R8" : "R10");
    if (poke) begin
      @(negedge clk);
      @(negedge clk);
      hits = ~h;
      for (int c = 0; c < N; c++) vals[c*W +: W] = 8'hA5;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (exp_q.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    logic [N-1:0] h;
    repeat (3) @(negedge clk);
    check(valid == 1'b0, "R9", "valid in reset", int'(valid), 0);
    check(eor == 1'b0, "R9", "eor in reset", int'(eor), 0);
    check(data == '0, "R9", "bus in reset", int'(data), 0);
    rst = 1'b0;
    armed = 1'b1;

    run_event('0, 1, 1'b0);                       // R7 empty event
    h = '0; h[0] = 1'b1;   run_event(h, 2, 1'b0); // R2 single hit low
    h = '0; h[127] = 1'b1; run_event(h, 3, 1'b0); // R5 seven empty windows
    h = '0; h[0] = 1'b1; h[16] = 1'b1; run_event(h, 4, 1'b0); // R4 edge of window
    h = '0; h[0] = 1'b1; h[17] = 1'b1; run_event(h, 5, 1'b0); // R5 one idle cycle
    run_event('1, 6, 1'b0);                       // R4 fully dense
    h = '0; for (int c = 0; c < N; c += 20) h[c] = 1'b1; run_event(h, 7, 1'b0);
    h = '0; for (int c = 40; c < 52; c++) h[c] = 1'b1; run_event(h, 8, 1'b0);
    for (int r = 0; r < 8; r++) begin
      h = '0;
      for (int k = 0; k < 3 + r; k++) h[$urandom_range(N - 1)] = 1'b1;
      run_event(h, 20 + r, 1'b0);
    end
    h = '0; h[3] = 1'b1; h[70] = 1'b1; h[71] = 1'b1; run_event(h, 9, 1'b1); // R8

    // R9: reset in the middle of a dense readout.
    @(negedge clk);
    hits = '1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(valid == 1'b0, "R9", "valid after mid reset", int'(valid), 0);
    check(eor == 1'b0, "R9", "eor after mid reset", int'(eor), 0);
    rst = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(valid == 1'b0 && eor == 1'b0 && data == '0, "R9", "idle after reset",
            int'({valid, eor, data}), 0);
    end
    h = '0; h[5] = 1'b1; run_event(h, 10, 1'b0); // R1 restart after reset

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule